// File: doc/BRIEF.md
# Fixed Off-Time Chopping Timer

This block times one current-chopping cycle for a bridge driver. It counts whole periods of a free-running oscillator, which reach the block as a one-cycle `tick` enable on the system clock. While the source side is conducting and not blanked, a trip from the current-sense comparator turns the source off. An off interval of coded length then follows. In mixed decay, the first part of that interval is fast decay and the remainder is slow decay. In slow decay, the whole interval is slow decay.

When the off interval ends, the source turns back on and a blanking window opens. While that window is open, comparator trips are discarded, so the turn-on current spike cannot chop the bridge a second time. A separate `restart` pulse stands for a direction change or an externally commanded chop. It drops any off interval in progress and starts a fresh blanking window at once. The comparator itself is outside the block.

Top module: `fot_pwm_timer`

## Requirements
- R1: After reset, `src_on` is 1 and `blanking`, `fast_on` and `slow_on` are 0.
- R2: A clock cycle with `tick`=1, `trip`=1, `src_on`=1, `blanking`=0 and `restart`=0 drives `src_on` to 0 after that edge. In that same step, `fast_on` takes the value `mixed` had.
- R3: An off interval lasts 8·N+7 ticks, where N is the unsigned value of `off_code` (0 to 31). At the tick that ends it, `src_on` returns to 1.
- R4: With `mixed`=1, fast decay covers the first 8·M+7 ticks of the off interval, where M is `fast_code` (0 to 15), and slow decay covers the rest. When 8·M+7 is at least the off length, the whole interval is fast decay.
- R5: With `mixed`=0, the whole off interval is slow decay and `fast_code` has no effect.
- R6: `blanking` rises together with `src_on` at the end of an off interval and lasts 4, 6, 12 or 24 ticks for `blank_sel` = 0, 1, 2 or 3.
- R7: While `blanking` is 1, `trip` never turns the source off.
- R8: On any cycle, `restart`=1 ends an off interval, sets `src_on` and `blanking` to 1, and loads the blanking length from the current `blank_sel` (lengths as in R6). It does not wait for a tick, and it overrides a trip in the same cycle.
- R9: `off_code`, `fast_code`, `mixed` and `blank_sel` are sampled at the trip. Changing them during the off interval or the following blanking window does not alter that cycle.
- R10: On a cycle with `tick`=0 and `restart`=0, none of the outputs change.
- R11: While `src_on` is 0, exactly one of `fast_on` and `slow_on` is 1. While `src_on` is 1, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One oscillator period has elapsed |
| trip | input | 1 | Current-sense comparator has tripped |
| restart | input | 1 | Direction change or external chop event |
| mixed | input | 1 | 1 selects mixed decay, 0 selects slow decay |
| off_code | input | 5 | Off-interval length code N |
| fast_code | input | 4 | Fast-decay length code M |
| blank_sel | input | 2 | Blanking length select |
| src_on | output | 1 | Source driver enabled |
| fast_on | output | 1 | Fast decay active |
| slow_on | output | 1 | Slow decay active |
| blanking | output | 1 | Comparator trips are being ignored |

## Verification
A corrupted off or fast counter shows up at the end of the off interval. `src_on` returns to 1, or `fast_on` hands over to `slow_on`, some number of ticks early or late, so the error appears within one chop period. That period is at most 255 ticks. A stuck blanking counter either lets a trip through immediately after turn-on or keeps the bridge from ever chopping again. A lost `fast_ph` bit puts the wrong decay flag up starting in the cycle right after the trip. The bench therefore counts the number of cycles each output level lasts, for each code pattern, and also probes trips and code changes at the edges of these windows.

// File: rtl/fot_pwm_timer.sv
`timescale 1ns/1ps
module fot_pwm_timer #(
  parameter int OFF_W  = 5,
  parameter int FAST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trip,
  input  logic              restart,
  input  logic              mixed,
  input  logic [OFF_W-1:0]  off_code,
  input  logic [FAST_W-1:0] fast_code,
  input  logic [1:0]        blank_sel,
  output logic              src_on,
  output logic              fast_on,
  output logic              slow_on,
  output logic              blanking
);
  localparam int OCW = OFF_W + 3;
  localparam int FCW = FAST_W + 3;
  localparam int BCW = 5;

  logic [OCW-1:0] off_cnt;
  logic [FCW-1:0] fast_cnt;
  logic [BCW-1:0] blank_cnt;
  logic [1:0]     blank_lat;
  logic           fast_ph;

  function automatic logic [BCW-1:0] blank_len(input logic [1:0] sel);
    case (sel)
      2'd0:    blank_len = BCW'(4);
      2'd1:    blank_len = BCW'(6);
      2'd2:    blank_len = BCW'(12);
      default: blank_len = BCW'(24);
    endcase
  endfunction

  wire arm = tick && trip && src_on && !blanking;

  assign fast_on = !src_on && fast_ph;
  assign slow_on = !src_on && !fast_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_on    <= 1'b1;
      blanking  <= 1'b0;
      fast_ph   <= 1'b0;
      off_cnt   <= '0;
      fast_cnt  <= '0;
      blank_cnt <= '0;
      blank_lat <= '0;
    end else if (restart) begin
      src_on    <= 1'b1;
      fast_ph   <= 1'b0;
      off_cnt   <= '0;
      fast_cnt  <= '0;
      blanking  <= 1'b1;
      blank_cnt <= blank_len(blank_sel);
    end else if (arm) begin
      src_on    <= 1'b0;
      off_cnt   <= {off_code, 3'b111};
      fast_cnt  <= {fast_code, 3'b111};
      fast_ph   <= mixed;
      blank_lat <= blank_sel;
    end else if (tick) begin
      if (!src_on) begin
        if (fast_cnt > FCW'(1)) begin
          fast_cnt <= fast_cnt - FCW'(1);
        end else begin
          fast_cnt <= '0;
          fast_ph  <= 1'b0;
        end
        if (off_cnt == OCW'(1)) begin
          src_on    <= 1'b1;
          fast_ph   <= 1'b0;
          off_cnt   <= '0;
          blanking  <= 1'b1;
          blank_cnt <= blank_len(blank_lat);
        end else begin
          off_cnt <= off_cnt - OCW'(1);
        end
      end else if (blanking) begin
        if (blank_cnt == BCW'(1)) blanking <= 1'b0;
        blank_cnt <= blank_cnt - BCW'(1);
      end
    end
  end
endmodule

// File: rtl/fot_pwm_timer_chk.sv
`timescale 1ns/1ps
module fot_pwm_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic trip,
  input logic restart,
  input logic mixed,
  input logic src_on,
  input logic fast_on,
  input logic slow_on,
  input logic blanking
);
  AST_TRIP_CHOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && trip && src_on && !blanking && !restart) |=> (!src_on && fast_on == $past(mixed))); // R2

  AST_BLANK_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_on) |-> blanking); // R6

  AST_BLANK_IGNORES_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && !restart) |=> src_on); // R7

  AST_RESTART_REBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (src_on && blanking)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> ($stable(src_on) && $stable(blanking) && $stable(fast_on) && $stable(slow_on))); // R10

  AST_ONE_DECAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !src_on |-> $onehot({fast_on, slow_on})); // R11

  AST_NO_DECAY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    src_on |-> !(fast_on || slow_on)); // R11

  AST_FAST_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_on) |-> $fell(src_on)); // R4
endmodule

bind fot_pwm_timer fot_pwm_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .trip(trip), .restart(restart),
  .mixed(mixed), .src_on(src_on), .fast_on(fast_on), .slow_on(slow_on),
  .blanking(blanking)
);

// File: tb/tb_fot_pwm_timer.sv
`timescale 1ns/1ps
module tb_fot_pwm_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, trip = 1'b0, restart = 1'b0, mixed = 1'b0;
  logic [4:0] off_code = '0;
  logic [3:0] fast_code = '0;
  logic [1:0] blank_sel = '0;
  logic src_on, fast_on, slow_on, blanking;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fot_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trip(trip), .restart(restart),
    .mixed(mixed), .off_code(off_code), .fast_code(fast_code), .blank_sel(blank_sel),
    .src_on(src_on), .fast_on(fast_on), .slow_on(slow_on), .blanking(blanking)
  );

  // N, M, sel, mixed, expected off, fast, blank ticks
  localparam int NV = 7;
  localparam int VEC [NV][7] = '{
    '{0,  0,  0, 1,   7,   7,  4},
    '{3,  1,  1, 1,  31,  15,  6},
    '{31, 15, 3, 1, 255, 127, 24},
    '{2,  5,  2, 1,  23,  23, 12},
    '{5,  2,  0, 0,  47,   0,  4},
    '{1,  0,  3, 0,  15,   0, 24},
    '{7,  7,  1, 1,  63,  63,  6}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (!(src_on && !blanking)) @(negedge clk);
  endtask

  task automatic count_off(output int o, output int f, output int s);
    o = 0; f = 0; s = 0;
    while (!src_on) begin
      o++;
      if (fast_on) f++;
      if (slow_on) s++;
      @(negedge clk);
    end
  endtask

  task automatic count_blank(output int b);
    b = 0;
    while (blanking) begin
      b++;
      @(negedge clk);
    end
  endtask

  task automatic fire(input int n, input int m, input int sel, input bit mx);
    off_code = 5'(n); fast_code = 4'(m); blank_sel = 2'(sel); mixed = mx;
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int o, f, s, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(src_on == 1'b1,  "R1 src_on",   src_on, 1);
    check(blanking == 1'b0, "R1 blanking", blanking, 0);
    check(fast_on == 1'b0, "R1 fast_on",  fast_on, 0);
    check(slow_on == 1'b0, "R1 slow_on",  slow_on, 0);

    for (int i = 0; i < NV; i++) begin
      wait_idle();
      fire(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3] != 0);
      check(src_on == 1'b0, "R2 chop", src_on, 0);
      count_off(o, f, s);
      check(o == VEC[i][4], "R3 off length", o, VEC[i][4]);
      check(f == VEC[i][5], VEC[i][3] != 0 ? "R4 fast length" : "R5 fast length", f, VEC[i][5]);
      check(s == VEC[i][4] - VEC[i][5], VEC[i][3] != 0 ? "R4 slow length" : "R5 slow length", s, VEC[i][4] - VEC[i][5]);
      count_blank(b);
      check(b == VEC[i][6], "R6 blank length", b, VEC[i][6]);
    end

    // R9: codes changed right after the trip leave this cycle alone
    wait_idle();
    fire(0, 15, 0, 1'b1);
    off_code = 5'd31; fast_code = 4'd0; blank_sel = 2'd3; mixed = 1'b0;
    count_off(o, f, s);
    check(o == 7, "R9 off kept", o, 7);
    check(f == 7, "R9 mode kept", f, 7);
    count_blank(b);
    check(b == 4, "R9 blank kept", b, 4);

    // R7: trips inside blanking are ignored
    wait_idle();
    fire(0, 0, 3, 1'b0);
    count_off(o, f, s);
    trip = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(src_on == 1'b1, "R7 trip ignored", src_on, 1);
    end
    trip = 1'b0;

    // R10: no tick, no change
    wait_idle();
    tick = 1'b0; trip = 1'b1; off_code = 5'd0; blank_sel = 2'd0; mixed = 1'b0;
    repeat (4) @(negedge clk);
    check(src_on == 1'b1, "R10 no tick no chop", src_on, 1);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; trip = 1'b0;
    repeat (10) @(negedge clk);
    check(src_on == 1'b0, "R10 off held", src_on, 0);
    check(slow_on == 1'b1, "R10 decay held", slow_on, 1);
    tick = 1'b1;
    count_off(o, f, s);
    check(o == 7, "R10 off resumes", o, 7);

    // R8: restart during an off interval
    wait_idle();
    fire(31, 0, 0, 1'b0);
    repeat (5) @(negedge clk);
    restart = 1'b1; blank_sel = 2'd2; trip = 1'b1;
    @(negedge clk);
    restart = 1'b0; trip = 1'b0;
    check(src_on == 1'b1,  "R8 source back", src_on, 1);
    check(blanking == 1'b1, "R8 blanking", blanking, 1);
    count_blank(b);
    check(b == 12, "R8 live blank length", b, 12);

    // R8: restart acts with tick low
    tick = 1'b0;
    restart = 1'b1; blank_sel = 2'd1;
    @(negedge clk);
    restart = 1'b0;
    check(blanking == 1'b1, "R8 without tick", blanking, 1);
    tick = 1'b1;
    count_blank(b);
    check(b == 6, "R8 blank after untimed restart", b, 6);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule